// File: doc/BRIEF.md
# Lane-Masked Block Memory

This block is a synthesizable behavioural model of an 18-kilobit on-chip memory with a single synchronous port. A parameter sets the data width to 1, 2, 4, 9, 18 or 36 bits. The address bus is always 14 bits wide. At narrow widths the spare low bits of that bus are ignored. At the two widest settings, the same low bits carry per-lane write enables, where each lane is 9 bits. This lets a caller update single 9-bit lanes of a wide word without extra pins.

Reads are registered and take one clock. A read and a write on the same edge return the word as it stood before the write. A second parameter chooses whether the reset that clears the read register is sampled on the clock or acts at once.

Top module: `bram_lane_mem`

## Requirements
- R1: `DATA_W` is one of 1, 2, 4, 9, 18 or 36. The word count is 16384/`DATA_W` below 9 and 18432/`DATA_W` from 9 upward. `SYNC_RST` = 1 selects a clocked reset and 0 selects an immediate reset.
- R2: The word index is `addr[13:S]`. S is 0, 1, 2, 3, 4 and 5 for widths 1, 2, 4, 9, 18 and 36. At widths below 18, the address bits under S have no effect.
- R3: At width 18, `addr[0]` enables writing `wdata[8:0]` and `addr[1]` enables writing `wdata[17:9]`.
- R4: At width 36, `addr[k]` (k = 0..3) enables writing lane k, which is `wdata[9k+8:9k]`.
- R5: At widths below 18, every write replaces the whole word.
- R6: A write happens on a rising clock edge only when both `ce` and `we` are high.
- R7: `rdata` shows the addressed word one edge after a read. When the same edge also writes that word, `rdata` shows the contents from before the write.
- R8: While `ce` is low, `rdata` keeps its value.
- R9: A high `rst` clears `rdata` to zero and takes priority over a read. This happens at the next edge when `SYNC_RST` = 1, and at once when it is 0. Reset does not alter the stored words.
- R10: Lanes whose enable bit is low keep their earlier contents.
- R11: A write is dropped if the reserved address bits are not zero. These are `addr[3:2]` at width 18 and `addr[4]` at width 36.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| ce | input | 1 | Clock enable for reads and writes |
| we | input | 1 | Write request |
| rst | input | 1 | Active-high clear of the read register |
| addr | input | 14 | Word index, plus lane enables at widths 18 and 36 |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
The properties assume three things about the inputs:
- `ce`, `we` and `rst` are never unknown at a clock edge.
- Reset is held from time zero until the first edge.
- Any all-lanes write that the read-back property follows has its reserved bits at zero.

The stimulus meets these conditions. It drives every control from time zero with reset high. It keeps the reserved bits at zero in the random phase. It sets them only in one directed step, and that step has no all-lanes pattern. The only reset raised between edges is the one on the instance built with immediate reset.

// File: rtl/bram_lane_mem.sv
module bram_lane_mem #(
  parameter int DATA_W   = 36,
  parameter bit SYNC_RST = 1'b1
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              we,
  input  logic              rst,
  input  logic [13:0]       addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int SH    = (DATA_W == 1) ? 0 : (DATA_W == 2) ? 1 : (DATA_W == 4) ? 2 :
                         (DATA_W == 9) ? 3 : (DATA_W == 18) ? 4 : 5;
  localparam int AW    = 14 - SH;
  localparam int DEPTH = 1 << AW;
  localparam int NL    = (DATA_W >= 18) ? DATA_W / 9 : 1;
  localparam int LW    = DATA_W / NL;
  localparam logic [13:0] RSV = (DATA_W == 36) ? 14'h0010 :
                                (DATA_W == 18) ? 14'h000C : 14'h0000;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     idx;
  logic [NL-1:0]     lane_en;
  logic              wr_ok;

  assign idx   = addr[13:SH];
  assign wr_ok = ce && we && ((addr & RSV) == 14'h0000);

  generate
    if (NL > 1) begin : g_lanes
      assign lane_en = addr[NL-1:0];
    end else begin : g_whole
      assign lane_en = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      for (int l = 0; l < NL; l++) begin
        if (lane_en[l]) mem[idx][l*LW +: LW] <= wdata[l*LW +: LW];
      end
    end
  end

  generate
    if (SYNC_RST) begin : g_srst
      always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (ce) rdata <= mem[idx];
      end
    end else begin : g_arst
      always_ff @(posedge clk or posedge rst) begin
        if (rst)     rdata <= '0;
        else if (ce) rdata <= mem[idx];
      end
    end
  endgenerate
endmodule

// File: rtl/bram_lane_mem_chk.sv
module bram_lane_mem_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              ce,
  input logic              we,
  input logic              rst,
  input logic [13:0]       addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata
);
  localparam logic [4:0] FMASK = (DATA_W == 36) ? 5'h1F : (DATA_W == 18) ? 5'h0F : 5'h00;
  localparam logic [4:0] FPAT  = (DATA_W == 36) ? 5'h0F : (DATA_W == 18) ? 5'h03 : 5'h00;

  logic full;
  assign full = ((addr[4:0] & FMASK) == FPAT);

  a_r6_ctrl_known: assert property (@(posedge clk) !$isunknown({ce, we, rst}));

  a_r8_hold_without_ce: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(rdata));

  a_r9_reset_zero: assert property (@(posedge clk)
    rst |=> (rdata == '0));

  // R3 and R4: an all-lanes write read back on the next edge
  a_r4_full_write_readback: assert property (@(posedge clk) disable iff (rst)
    (ce && we && full) ##1 (ce && !we && $stable(addr)) |=> (rdata == $past(wdata, 2)));
endmodule

bind bram_lane_mem bram_lane_mem_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .ce(ce), .we(we), .rst(rst), .addr(addr), .wdata(wdata), .rdata(rdata)
);

// File: tb/tb_bram_lane_mem.sv
module tb_bram_lane_mem;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic ce, we, rst;
  logic [13:0] a36, a18, a4;
  logic [35:0] d36, r36;
  logic [17:0] d18, r18;
  logic [3:0]  d4, r4;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R9 reset";

  always #(CLK_P/2) clk = ~clk;

  bram_lane_mem #(.DATA_W(36), .SYNC_RST(1'b1)) dut (
    .clk(clk), .ce(ce), .we(we), .rst(rst), .addr(a36), .wdata(d36), .rdata(r36));
  bram_lane_mem #(.DATA_W(18), .SYNC_RST(1'b0)) dut18 (
    .clk(clk), .ce(ce), .we(we), .rst(rst), .addr(a18), .wdata(d18), .rdata(r18));
  bram_lane_mem #(.DATA_W(4), .SYNC_RST(1'b1)) dut4 (
    .clk(clk), .ce(ce), .we(we), .rst(rst), .addr(a4), .wdata(d4), .rdata(r4));

  logic [35:0] m36 [512];
  logic [17:0] m18 [1024];
  logic [3:0]  m4  [4096];
  bit v36 [512];
  bit v18 [1024];
  bit v4  [4096];
  logic [35:0] e36;
  logic [17:0] e18;
  logic [3:0]  e4;
  bit k36 = 0, k18 = 0, k4 = 0;

  always @(posedge clk) begin
    int j36, j18, j4;
    j36 = int'(a36[13:5]);
    j18 = int'(a18[13:4]);
    j4  = int'(a4[13:2]);
    if (rst) begin e36 = '0; e18 = '0; e4 = '0; k36 = 1; k18 = 1; k4 = 1; end
    else if (ce) begin
      e36 = m36[j36]; k36 = v36[j36];
      e18 = m18[j18]; k18 = v18[j18];
      e4  = m4[j4];   k4  = v4[j4];
    end
    if (ce && we) begin
      if (!a36[4]) begin
        for (int l = 0; l < 4; l++) if (a36[l]) m36[j36][9*l +: 9] = d36[9*l +: 9];
        if (a36[3:0] == 4'hF) v36[j36] = 1;
      end
      if (a18[3:2] == 2'b00) begin
        for (int l = 0; l < 2; l++) if (a18[l]) m18[j18][9*l +: 9] = d18[9*l +: 9];
        if (a18[1:0] == 2'b11) v18[j18] = 1;
      end
      m4[j4] = d4;
      v4[j4] = 1;
    end
  end

  always @(posedge rst) begin
    e18 = '0;
    k18 = 1;
  end

  task automatic chk(string t, logic [35:0] got, logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic compare();
    if (k36) chk({tag, " width36"}, r36, e36);
    if (k18) chk({tag, " width18"}, {18'b0, r18}, {18'b0, e18});
    if (k4)  chk({tag, " width4"},  {32'b0, r4},  {32'b0, e4});
  endtask

  task automatic step(bit c, bit w, bit r,
                      logic [13:0] x36, logic [35:0] y36,
                      logic [13:0] x18, logic [17:0] y18,
                      logic [13:0] x4,  logic [3:0]  y4, string t);
    ce = c; we = w; rst = r;
    a36 = x36; d36 = y36; a18 = x18; d18 = y18; a4 = x4; d4 = y4;
    tag = t;
    @(negedge clk);
    compare();
  endtask

  function automatic logic [35:0] rnd36();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[35:0];
  endfunction

  initial begin
    logic [35:0] av, bv, ev, mix36;
    logic [17:0] a18v, b18v, e18v, mix18;
    logic [31:0] rr;
    ce = 0; we = 0; rst = 1;
    a36 = '0; a18 = '0; a4 = '0; d36 = '0; d18 = '0; d4 = '0;
    @(negedge clk);
    step(0, 0, 1, 14'd0, '0, 14'd0, '0, 14'd0, '0, "R9 reset state");
    chk("R9 reset state width36", r36, 36'h0);
    chk("R9 reset state width18", {18'b0, r18}, 36'h0);

    for (int i = 0; i < 4096; i++) begin
      rr = $urandom();
      step(1, 1, 0, {9'(i % 512), 5'b01111}, rnd36(),
           {10'(i % 1024), 4'b0011}, rr[17:0],
           {12'(i), 2'(rr[21:20])}, rr[27:24], "R1 R5 R6 fill");
    end

    for (int i = 0; i < 3000; i++) begin
      rr = $urandom();
      step(rr[2:0] != 3'b000, rr[3], rr[9:4] == 6'd0,
           {9'(rr[15:10]), 1'b0, rr[19:16]}, rnd36(),
           {10'(rr[25:20]), 2'b00, rr[27:26]}, rnd36() >> 18,
           {12'(rr[31:26]), 2'(rr[1:0])}, rr[7:4], "R2 R3 R4 R7 R10 random");
    end

    av = 36'hA5A5A5A5A; bv = 36'h3C3C3C3C3; ev = 36'h0F1E2D3C4;
    a18v = 18'h2AAAA; b18v = 18'h15555; e18v = 18'h0C0C3;
    mix36 = {av[35:27], bv[26:18], av[17:9], bv[8:0]};
    mix18 = {a18v[17:9], b18v[8:0]};

    step(1, 1, 0, {9'd7, 5'b01111}, av, {10'd7, 4'b0011}, a18v, {12'd7, 2'd0}, 4'h9, "R3 R4 R5 all lanes");
    step(1, 1, 0, {9'd7, 5'b00101}, bv, {10'd7, 4'b0001}, b18v, {12'd7, 2'd0}, 4'h9, "R3 R4 partial");
    step(1, 0, 0, {9'd7, 5'b0}, '0, {10'd7, 4'b0}, '0, {12'd7, 2'd0}, 4'h0, "R10 read");
    chk("R10 width36 unselected lanes", r36, mix36);
    chk("R10 width18 unselected lane", {18'b0, r18}, {18'b0, mix18});

    step(0, 1, 0, {9'd7, 5'b01111}, ev, {10'd7, 4'b0011}, e18v, {12'd7, 2'd0}, 4'h1, "R8 ce low");
    chk("R8 hold width36", r36, mix36);
    step(1, 0, 0, {9'd7, 5'b01111}, ev, {10'd7, 4'b0011}, e18v, {12'd7, 2'd0}, 4'h1, "R6 we low");
    chk("R6 ce low write ignored", r36, mix36);
    step(1, 0, 0, {9'd7, 5'b0}, '0, {10'd7, 4'b0}, '0, {12'd7, 2'd0}, 4'h0, "R6 reread");
    chk("R6 we low write ignored", r36, mix36);
    chk("R6 width18 unchanged", {18'b0, r18}, {18'b0, mix18});

    step(1, 1, 0, {9'd7, 5'b11111}, ev, {10'd7, 4'b0111}, e18v, {12'd7, 2'd0}, 4'h9, "R11 reserved set");
    step(1, 0, 0, {9'd7, 5'b0}, '0, {10'd7, 4'b0}, '0, {12'd7, 2'd0}, 4'h0, "R11 reread");
    chk("R11 width36 write dropped", r36, mix36);
    chk("R11 width18 write dropped", {18'b0, r18}, {18'b0, mix18});

    step(1, 1, 0, {9'd7, 5'b01111}, ev, {10'd7, 4'b0011}, e18v, {12'd7, 2'd0}, 4'h9, "R7 write");
    chk("R7 old data on same-edge write", r36, mix36);
    chk("R7 old data width18", {18'b0, r18}, {18'b0, mix18});
    step(1, 0, 0, {9'd7, 5'b0}, '0, {10'd7, 4'b0}, '0, {12'd7, 2'd0}, 4'h0, "R7 reread");
    chk("R7 new data", r36, ev);

    step(1, 1, 0, {9'd7, 5'b0}, '0, {10'd7, 4'b0}, '0, {12'd20, 2'd2}, 4'h6, "R2 write");
    step(1, 0, 0, {9'd7, 5'b0}, '0, {10'd7, 4'b0}, '0, {12'd20, 2'd1}, 4'h0, "R2 read");
    chk("R2 low bits ignored width4", {32'b0, r4}, 36'h6);
    chk("R2 no-lane write left width36", r36, ev);

    ce = 1; we = 0; rst = 1; tag = "R9 reset";
    #1;
    chk("R9 immediate clear width18", {18'b0, r18}, 36'h0);
    chk("R9 clocked clear waits width36", r36, ev);
    @(negedge clk);
    compare();
    chk("R9 clocked clear width36", r36, 36'h0);
    chk("R9 clocked clear width4", {32'b0, r4}, 36'h0);
    step(1, 0, 0, {9'd7, 5'b0}, '0, {10'd7, 4'b0}, '0, {12'd20, 2'd0}, 4'h0, "R9 contents kept");
    chk("R9 contents kept width36", r36, ev);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule